// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block moves one byte at a time over a single bidirectional data line, timed by a serial clock that the block generates itself. The data line is modelled as three signals: an input, an output and an output enable. A strobe that writes a byte into the shared data buffer starts a transmission. The byte leaves on the data line least significant bit first, one bit per serial clock period. Raising the receive enable starts a reception instead. Eight bits are taken from the data line, one on each serial clock rising edge, and they fill the same buffer from the top so that the first bit ends up in bit 0.

One serial clock period lasts PERIOD system clock cycles, twelve by default. Outgoing data changes one cycle after each rising edge and then holds for the rest of the period, so it is stable for SETUP (eleven) cycles before the next rising edge. Between transfers the serial clock rests high and the data output is released. A done flag for each direction goes high together with the eighth rising edge and stays high until its clear input is pulsed. While a flag is set, the matching start request is ignored.

A three-state controller sets the sequence. Its states are IDLE, TX and RX, and it has four transitions:
- start-transmit: IDLE to TX, on a write strobe while the transmit flag is clear.
- start-receive: IDLE to RX, on the receive enable while the receive flag is clear and no start-transmit is taken in the same cycle.
- finish-transmit: TX to IDLE, at the end of the eighth bit slot.
- finish-receive: RX to IDLE, at the end of the eighth bit slot.

Top module: `shreg_serial_port`

## Requirements
- R1: While reset is asserted: `sclk`=1, `sd_oe`=0, `tx_done`=0 and `rx_done`=0.
- R2: A transfer makes exactly 8 rising edges of `sclk`. The first comes 12 clock edges after the edge that accepts the start, and each later one comes exactly 12 cycles after the one before. `sclk` never stays low for only one cycle.
- R3: In a transmit, at the k-th rising edge of `sclk` (k = 0..7), `sd_oe`=1 and `sd_out` equals bit k of the written byte, so the least significant bit goes first.
- R4: During a transmit, `sd_out` is unchanged for the 11 cycles before each `sclk` rising edge and in the cycle in which `sclk` is first high.
- R5: In a receive, `sd_in` is sampled at each `sclk` rising edge and `sd_oe` stays 0. After the eighth edge, `rx_buf` bit k holds the k-th sampled value.
- R6: `tx_done` (after a transmit) or `rx_done` (after a receive) rises in the same cycle as the eighth `sclk` rising edge. It then stays 1 until its clear input (`clr_tx_done` / `clr_rx_done`) is high at a clock edge.
- R7: A write strobe while `tx_done`=1, or a receive enable while `rx_done`=1, is ignored. `sclk` stays high and `rx_buf` keeps its value.
- R8: Write strobes during a transfer are ignored. The bits sent and the final buffer content are those of the first byte.
- R9: After a transmit, `rx_buf` again equals the transmitted byte. The buffer keeps its content through reset.
- R10: If a write strobe and the receive enable arrive in the same idle cycle, a transmit is started.
- R11: When idle, `sclk`=1 and `sd_oe`=0. After a transmit, `sd_oe` falls on the first clock edge after the eighth `sclk` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | Buffer write strobe; starts a transmit |
| wr_data | input | NBITS | Byte written by the strobe |
| rx_en | input | 1 | Receive enable level; starts a receive |
| clr_tx_done | input | 1 | Clears the transmit-done flag |
| clr_rx_done | input | 1 | Clears the receive-done flag |
| sd_in | input | 1 | Data line, input side |
| sd_out | output | 1 | Data line, output side |
| sd_oe | output | 1 | Data line output enable |
| sclk | output | 1 | Generated serial clock, idles high |
| rx_buf | output | NBITS | Shared data buffer contents |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |

## Verification
Every one of the 256 byte values is transmitted and every one is received. The sweep separates bit order, each bit position and the sampling edge, and it covers runs of equal bits, where the data line does not toggle, as well as alternating bits. Further directed patterns check the following:
- strobes while a flag is set, to show the start gating;
- a second strobe in the middle of a transmit, to show it does not corrupt the buffer;
- a simultaneous strobe and receive enable, to show the priority;
- a reset after a transfer, to show the buffer survives it.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_RX   = 2'd2
    } xfer_state_t;

endpackage

// File: rtl/shreg_timing.sv
// Phase and bit-slot counters for one transfer.
module shreg_timing #(
    parameter int PERIOD = 12,
    parameter int NBITS  = 8,
    parameter int PH_W   = $clog2(PERIOD),
    parameter int BIT_W  = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    output logic [PH_W-1:0]  phase,
    output logic             slot_end,
    output logic             last_slot
);

    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PERIOD - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(NBITS - 1);

    logic [BIT_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= '0;
            slot_q <= '0;
        end else if (!active) begin
            phase  <= '0;
            slot_q <= '0;
        end else if (phase == PH_LAST) begin
            phase  <= '0;
            slot_q <= slot_q + 1'b1;
        end else begin
            phase  <= phase + 1'b1;
        end
    end

    always_comb begin
        slot_end  = active && (phase == PH_LAST);
        last_slot = (slot_q == BIT_LAST);
    end

endmodule

// File: rtl/shreg_buffer.sv
// Shared data buffer: loaded by a write, shifted right once per bit slot.
// Deliberately has no reset.
module shreg_buffer #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             load,
    input  logic [NBITS-1:0] load_data,
    input  logic             shift,
    input  logic             shift_in,
    output logic [NBITS-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (load) begin
            data_q <= load_data;
        end else if (shift) begin
            data_q <= {shift_in, data_q[NBITS-1:1]};
        end
    end

endmodule

// File: rtl/shreg_ctrl.sv
// Transfer sequencer: state register, next-state logic and registered outputs.
module shreg_ctrl
    import shreg_pkg::*;
#(
    parameter int PERIOD = 12,
    parameter int SETUP  = 11,
    parameter int PH_W   = $clog2(PERIOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic            rx_en,
    input  logic            clr_tx_done,
    input  logic            clr_rx_done,
    input  logic [PH_W-1:0] phase,
    input  logic            slot_end,
    input  logic            last_slot,
    input  logic            buf_lsb,
    output logic            active,
    output logic            load,
    output logic            rx_mode,
    output logic            sclk,
    output logic            sd_out,
    output logic            sd_oe,
    output logic            tx_done,
    output logic            rx_done
);

    localparam int FALL_PH = PERIOD / 2;
    localparam int RISE_PH = SETUP;
    localparam logic [PH_W-1:0] FALL_AT = PH_W'(FALL_PH);
    localparam logic [PH_W-1:0] RISE_AT = PH_W'(RISE_PH);

    xfer_state_t state_q, state_d;
    logic        start_tx, start_rx, finish, low_win;

    // next-state logic
    always_comb begin
        start_tx = (state_q == ST_IDLE) && wr_stb && !tx_done;
        start_rx = (state_q == ST_IDLE) && rx_en && !rx_done && !start_tx;
        finish   = slot_end && last_slot;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_tx)      state_d = ST_TX;
                else if (start_rx) state_d = ST_RX;
            end
            ST_TX:   if (finish) state_d = ST_IDLE;
            ST_RX:   if (finish) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // low part of each bit slot for the serial clock
    always_comb begin
        low_win = (phase >= FALL_AT) && (phase < RISE_AT);
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk    <= 1'b1;
            sd_out  <= 1'b1;
            sd_oe   <= 1'b0;
            tx_done <= 1'b0;
            rx_done <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sclk   <= 1'b1;
                    sd_out <= 1'b1;
                    sd_oe  <= 1'b0;
                end
                ST_TX: begin
                    sclk   <= !low_win;
                    sd_out <= buf_lsb;
                    sd_oe  <= 1'b1;
                end
                ST_RX: begin
                    sclk   <= !low_win;
                    sd_out <= 1'b1;
                    sd_oe  <= 1'b0;
                end
                default: begin
                    sclk   <= 1'b1;
                    sd_out <= 1'b1;
                    sd_oe  <= 1'b0;
                end
            endcase
            if ((state_q == ST_TX) && finish) tx_done <= 1'b1;
            else if (clr_tx_done)             tx_done <= 1'b0;
            if ((state_q == ST_RX) && finish) rx_done <= 1'b1;
            else if (clr_rx_done)             rx_done <= 1'b0;
        end
    end

    always_comb begin
        active  = (state_q != ST_IDLE);
        load    = start_tx;
        rx_mode = (state_q == ST_RX);
    end

endmodule

// File: rtl/shreg_serial_port.sv
// Synchronous shift-register serial port, top level.
module shreg_serial_port #(
    parameter int NBITS  = 8,
    parameter int PERIOD = 12,
    parameter int SETUP  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [NBITS-1:0] wr_data,
    input  logic             rx_en,
    input  logic             clr_tx_done,
    input  logic             clr_rx_done,
    input  logic             sd_in,
    output logic             sd_out,
    output logic             sd_oe,
    output logic             sclk,
    output logic [NBITS-1:0] rx_buf,
    output logic             tx_done,
    output logic             rx_done
);

    localparam int PH_W  = $clog2(PERIOD);
    localparam int BIT_W = $clog2(NBITS);

    logic [PH_W-1:0]  phase;
    logic             slot_end, last_slot;
    logic             active, load, rx_mode, shift_in;
    logic [NBITS-1:0] buf_q;

    shreg_timing #(
        .PERIOD (PERIOD),
        .NBITS  (NBITS),
        .PH_W   (PH_W),
        .BIT_W  (BIT_W)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .phase     (phase),
        .slot_end  (slot_end),
        .last_slot (last_slot)
    );

    // receive shifts the line in; transmit rotates the byte back into place
    always_comb begin
        shift_in = rx_mode ? sd_in : buf_q[0];
    end

    shreg_buffer #(
        .NBITS (NBITS)
    ) u_buffer (
        .clk       (clk),
        .load      (load),
        .load_data (wr_data),
        .shift     (slot_end),
        .shift_in  (shift_in),
        .data_q    (buf_q)
    );

    shreg_ctrl #(
        .PERIOD (PERIOD),
        .SETUP  (SETUP),
        .PH_W   (PH_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .rx_en       (rx_en),
        .clr_tx_done (clr_tx_done),
        .clr_rx_done (clr_rx_done),
        .phase       (phase),
        .slot_end    (slot_end),
        .last_slot   (last_slot),
        .buf_lsb     (buf_q[0]),
        .active      (active),
        .load        (load),
        .rx_mode     (rx_mode),
        .sclk        (sclk),
        .sd_out      (sd_out),
        .sd_oe       (sd_oe),
        .tx_done     (tx_done),
        .rx_done     (rx_done)
    );

    always_comb begin
        rx_buf = buf_q;
    end

endmodule

// File: rtl/shreg_sva.sv
// Protocol checker for the shift-register serial port.
module shreg_sva #(
    parameter int SETUP = 11
) (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic sd_out,
    input logic sd_oe,
    input logic tx_done,
    input logic rx_done,
    input logic clr_tx_done,
    input logic clr_rx_done
);

    logic       last_q;
    logic [7:0] run_q;

    // number of cycles the data output has held its current value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b1;
            run_q  <= 8'd0;
        end else begin
            last_q <= sd_out;
            if (sd_out != last_q)  run_q <= 8'd1;
            else if (run_q != 8'hFF) run_q <= run_q + 8'd1;
        end
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) && sd_oe) |-> $stable(sd_out));

    assert_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) && sd_oe) |-> (int'(run_q) >= SETUP));

    assert_tx_flag_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> ($rose(sclk) && sd_oe));

    assert_rx_flag_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> ($rose(sclk) && !sd_oe));

    assert_tx_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !clr_tx_done) |=> tx_done);

    assert_rx_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !clr_rx_done) |=> rx_done);

    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_oe) |-> (sclk && $stable(sclk)));

    assert_low_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |=> !sclk);

endmodule

bind shreg_serial_port shreg_sva #(.SETUP(SETUP)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .sd_out      (sd_out),
    .sd_oe       (sd_oe),
    .tx_done     (tx_done),
    .rx_done     (rx_done),
    .clr_tx_done (clr_tx_done),
    .clr_rx_done (clr_rx_done)
);

// File: tb/tb_shreg_serial_port.sv
module tb_shreg_serial_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rx_en = 1'b0;
    logic       clr_tx_done = 1'b0;
    logic       clr_rx_done = 1'b0;
    logic       sd_in = 1'b1;
    logic       sd_out, sd_oe, sclk, tx_done, rx_done;
    logic [7:0] rx_buf;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    shreg_serial_port dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .rx_en       (rx_en),
        .clr_tx_done (clr_tx_done),
        .clr_rx_done (clr_rx_done),
        .sd_in       (sd_in),
        .sd_out      (sd_out),
        .sd_oe       (sd_oe),
        .sclk        (sclk),
        .rx_buf      (rx_buf),
        .tx_done     (tx_done),
        .rx_done     (rx_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Follows one transfer whose start was driven at the current negedge.
    task automatic run_xfer(input logic [7:0] exp, input bit is_tx,
                            input int inj_at, input logic [7:0] inj_b);
        int   rises = 0;
        int   cyc = 0;
        int   last_rise = -1;
        int   stab = 0;
        logic prev_sclk = sclk;
        logic prev_sdo = sd_out;
        logic flag;
        while (rises < 8 && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1 && is_tx) rx_en = 1'b0;
            if (cyc == inj_at) begin
                wr_stb  = 1'b1;
                wr_data = inj_b;
            end else begin
                wr_stb = 1'b0;
            end
            stab = (sd_out !== prev_sdo) ? 1 : stab + 1;
            prev_sdo = sd_out;
            if (sclk && !prev_sclk) begin
                if (is_tx) begin
                    chk(sd_out == exp[rises], "R3 tx bit value", int'(sd_out), int'(exp[rises]));
                    chk(sd_oe == 1'b1, "R3 tx drive enable", int'(sd_oe), 1);
                    chk(stab >= 12, "R4 tx data stable window", stab, 12);
                end else begin
                    chk(sd_oe == 1'b0, "R5 rx line released", int'(sd_oe), 0);
                end
                if (last_rise < 0) chk(cyc == 13, "R2 first edge position", cyc, 13);
                else               chk(cyc - last_rise == 12, "R2 sclk period", cyc - last_rise, 12);
                last_rise = cyc;
                flag = is_tx ? tx_done : rx_done;
                chk(flag == (rises == 7), "R6 done flag timing", int'(flag), int'(rises == 7));
                rises++;
                if (!is_tx && rises < 8) sd_in = exp[rises];
            end
            prev_sclk = sclk;
        end
        chk(rises == 8, "R2 edge count", rises, 8);
        if (is_tx) chk(rx_buf == exp, "R9 buffer after transmit", int'(rx_buf), int'(exp));
        else       chk(rx_buf == exp, "R5 received byte", int'(rx_buf), int'(exp));
    endtask

    task automatic clear_flags();
        @(negedge clk);
        clr_tx_done = 1'b1;
        clr_rx_done = 1'b1;
        @(negedge clk);
        clr_tx_done = 1'b0;
        clr_rx_done = 1'b0;
        chk(!tx_done && !rx_done, "R6 flags cleared", int'({tx_done, rx_done}), 0);
    endtask

    task automatic start_tx(input logic [7:0] b);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = b;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic [7:0] keep;
        int         bad_idle;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(sclk == 1'b1, "R1 sclk in reset", int'(sclk), 1);
        chk(sd_oe == 1'b0, "R1 oe in reset", int'(sd_oe), 0);
        chk(!tx_done && !rx_done, "R1 flags in reset", int'({tx_done, rx_done}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // transmit sweep over all bytes (R3, R4, R2, R6, R11)
        for (int v = 0; v < 256; v++) begin
            start_tx(8'(v));
            run_xfer(8'(v), 1'b1, -1, 8'h00);
            @(negedge clk);
            chk(sd_oe == 1'b0 && sclk == 1'b1, "R11 release after transmit",
                int'({sd_oe, sclk}), 1);
            clear_flags();
        end

        // receive sweep over all bytes (R5, R2, R6)
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            rx_en = 1'b1;
            sd_in = v[0];
            run_xfer(8'(v), 1'b0, -1, 8'h00);
            rx_en = 1'b0;
            sd_in = 1'b1;
            clear_flags();
        end

        // R7 write ignored while tx_done set; R6 sticky
        start_tx(8'h6E);
        run_xfer(8'h6E, 1'b1, -1, 8'h00);
        start_tx(8'h5A);
        bad_idle = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            wr_stb = 1'b0;
            if (!sclk || sd_oe) bad_idle++;
        end
        chk(bad_idle == 0, "R7 no transfer while tx_done set", bad_idle, 0);
        chk(rx_buf == 8'h6E, "R7 buffer kept", int'(rx_buf), 8'h6E);
        chk(tx_done == 1'b1, "R6 tx_done sticky", int'(tx_done), 1);
        clear_flags();

        // R7 receive enable ignored while rx_done set
        @(negedge clk);
        rx_en = 1'b1;
        sd_in = 1'b1;
        run_xfer(8'h0F, 1'b0, -1, 8'h00);
        sd_in = 1'b0;
        bad_idle = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!sclk || sd_oe) bad_idle++;
        end
        chk(bad_idle == 0, "R7 no transfer while rx_done set", bad_idle, 0);
        chk(rx_buf == 8'h0F, "R7 rx buffer kept", int'(rx_buf), 8'h0F);
        chk(rx_done == 1'b1, "R6 rx_done sticky", int'(rx_done), 1);
        rx_en = 1'b0;
        clear_flags();

        // R8 strobe in the middle of a transmit
        start_tx(8'hA5);
        run_xfer(8'hA5, 1'b1, 40, 8'h3C);
        clear_flags();
        chk(rx_buf == 8'hA5, "R8 buffer unchanged by mid-transfer write", int'(rx_buf), 8'hA5);

        // R10 priority: strobe and receive enable together
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = 8'hC3;
        rx_en   = 1'b1;
        sd_in   = 1'b0;
        run_xfer(8'hC3, 1'b1, -1, 8'h00);
        chk(rx_done == 1'b0, "R10 no receive taken", int'(rx_done), 0);
        clear_flags();

        // R9 buffer survives reset
        start_tx(8'h96);
        run_xfer(8'h96, 1'b1, -1, 8'h00);
        clear_flags();
        keep = rx_buf;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rx_buf == 8'h96, "R9 buffer kept through reset", int'(rx_buf), 8'h96);
        chk(keep == 8'h96, "R9 buffer before reset", int'(keep), 8'h96);
        chk(sclk && !sd_oe && !tx_done && !rx_done, "R1 reset state again",
            int'({sclk, sd_oe, tx_done, rx_done}), 8);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sclk == 1'b1 && sd_oe == 1'b0, "R11 idle after reset", int'({sclk, sd_oe}), 2);

        summary();
        $finish;
    end

endmodule